// File: doc/BRIEF.md
# Program Counter with Six-Level Return Stack

This block holds the 12-bit fetch address of a small 8-bit controller core and decides, once per clock, where the next fetch comes from. It can advance by one, load an absolute target for a jump or a call, add a signed 8-bit displacement for a relative branch, or load a fixed interrupt or restart vector. It can also take the return address that sits in the first level of a shifting return stack.

A call and an interrupt entry both push a return address into level 1 and move the older entries one level deeper. A return and a return-from-interrupt both move every entry one level toward the counter. A small fill-state machine tracks the stack and has three states: FILL_EMPTY, FILL_PARTIAL and FILL_FULL. It has four named transitions:
- EMPTY→PARTIAL on the first push.
- PARTIAL→FULL on the push that reaches six entries.
- FULL→PARTIAL on a pop.
- PARTIAL→EMPTY on the pop that removes the last entry.

A synchronous restart in any state goes back to FILL_EMPTY. A push while full or a pop while empty leaves the state where it is and sets a sticky error flag.

The decoder drives a 3-bit command, a target, a displacement, an interrupt-entry strobe and a restart strobe. Restart wins over interrupt entry, and interrupt entry wins over the command.

Top module: `prog_counter_stack`

## Requirements
- R1: While rst_n is low, and on the clock edge after restart_i is high, pc_o is RST_VEC (default 0xFFE), depth_o is 0 and both sticky flags are 0. restart_i overrides irq_i and op_i, and in that cycle nothing is pushed.
- R2: Command code 0, and the spare codes 6 and 7, make the next pc_o equal to pc_o + 1 modulo 4096. The stack is left unchanged.
- R3: Command code 1 (jump) loads target_i into pc_o and leaves the stack unchanged.
- R4: Command code 2 (call) loads target_i into pc_o and pushes pc_o + 1 into level 1. depth_o increases by one.
- R5: Command code 3 (branch) loads pc_o plus offset_i into pc_o. offset_i is read as 8-bit two's complement, sign-extended, and the sum wraps modulo 4096.
- R6: With irq_i high and restart_i low, the next pc_o is IRQ_VEC (default 0xFF0). The current pc_o is pushed, and op_i is ignored for that cycle.
- R7: Command code 4 (return) and code 5 (return from interrupt) load the level-1 entry into pc_o and shift every entry one level toward the counter. depth_o decreases by one.
- R8: A push while six entries are held discards the level-6 entry and keeps depth_o at 6. It also sets overflow_o, which stays set until a reset.
- R9: A pop while the stack is empty loads the current level-1 contents into pc_o and keeps depth_o at 0. It also sets underflow_o, which stays set until a reset.
- R10: full_o is high exactly when depth_o is 6, and empty_o is high exactly when depth_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous restart to the reset vector, highest priority |
| irq_i | input | 1 | Interrupt entry strobe |
| op_i | input | 3 | Instruction next-address command code |
| target_i | input | 12 | Absolute jump or call address |
| offset_i | input | 8 | Signed branch displacement |
| pc_o | output | 12 | Current fetch address |
| depth_o | output | 3 | Number of stack entries held |
| full_o | output | 1 | Stack holds six entries |
| empty_o | output | 1 | Stack holds no entries |
| overflow_o | output | 1 | Sticky: push while full |
| underflow_o | output | 1 | Sticky: pop while empty |

## Verification
A corrupted stack level stays hidden until a return reaches that level. The bench therefore nests calls and interrupts up to the full depth and then unwinds every level. Each stale or misplaced entry then appears on pc_o on the clock edge after the return that uses it.

A fill state that disagrees with the count shows on full_o or empty_o on the very next edge. A wrong priority or wrong arithmetic shows on pc_o one edge after the command that triggers it.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        OP_STEP   = 3'd0,
        OP_JUMP   = 3'd1,
        OP_CALL   = 3'd2,
        OP_BRANCH = 3'd3,
        OP_RET    = 3'd4,
        OP_RETI   = 3'd5,
        OP_SPARE6 = 3'd6,
        OP_SPARE7 = 3'd7
    } pc_op_e;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PARTIAL,
        FILL_FULL
    } fill_e;

    typedef enum logic [2:0] {
        SRC_RESET,
        SRC_VECTOR,
        SRC_INC,
        SRC_ABS,
        SRC_REL,
        SRC_POP
    } src_e;

endpackage

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
    import pcs_pkg::*;
#(
    parameter int              PC_W    = 12,
    parameter int              OFF_W   = 8,
    parameter logic [PC_W-1:0] RST_VEC = 12'hFFE,
    parameter logic [PC_W-1:0] IRQ_VEC = 12'hFF0
) (
    input  logic             restart,
    input  logic             irq,
    input  logic [2:0]       op,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  target,
    input  logic [OFF_W-1:0] offset,
    input  logic [PC_W-1:0]  top,
    output logic [PC_W-1:0]  nxt_pc,
    output logic             push,
    output logic             pop,
    output logic [PC_W-1:0]  push_val
);

    localparam int EXT_W = PC_W - OFF_W;

    src_e            src;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] off_ext;

    assign pc_inc  = pc + PC_W'(1);
    assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};

    // source selection: restart, then interrupt entry, then instruction
    always_comb begin
        src  = SRC_INC;
        push = 1'b0;
        pop  = 1'b0;
        if (restart) begin
            src = SRC_RESET;
        end else if (irq) begin
            src  = SRC_VECTOR;
            push = 1'b1;
        end else begin
            unique case (pc_op_e'(op))
                OP_STEP, OP_SPARE6, OP_SPARE7: src = SRC_INC;
                OP_JUMP:                       src = SRC_ABS;
                OP_CALL: begin
                    src  = SRC_ABS;
                    push = 1'b1;
                end
                OP_BRANCH:                     src = SRC_REL;
                OP_RET, OP_RETI: begin
                    src = SRC_POP;
                    pop = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        unique case (src)
            SRC_RESET:  nxt_pc = RST_VEC;
            SRC_VECTOR: nxt_pc = IRQ_VEC;
            SRC_ABS:    nxt_pc = target;
            SRC_REL:    nxt_pc = pc + off_ext;
            SRC_POP:    nxt_pc = top;
            default:    nxt_pc = pc_inc;
        endcase
    end

    // interrupt entry returns to the address not yet fetched; a call returns past itself
    assign push_val = irq ? pc : pc_inc;

    always_comb begin
        a_r7_no_push_and_pop : assert (!(push && pop));
    end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack
    import pcs_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic [PC_W-1:0]  push_val,
    output logic [PC_W-1:0]  top,
    output logic [CNT_W-1:0] depth,
    output logic             full,
    output logic             empty,
    output logic             ovf_evt,
    output logic             unf_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [PC_W-1:0]  lvl [DEPTH];
    logic [CNT_W-1:0] cnt_q, cnt_d;
    fill_e            fill_q, fill_d;
    logic             do_shift_in, do_shift_out;

    assign do_shift_in  = push && !clear;
    assign do_shift_out = pop && !clear && (fill_q != FILL_EMPTY);

    // shifting storage: level 0 faces the program counter
    for (genvar i = 0; i < DEPTH; i++) begin : g_level
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            lvl[i] <= '0;
                else if (do_shift_in)  lvl[i] <= push_val;
                else if (do_shift_out) lvl[i] <= (DEPTH > 1) ? lvl[(DEPTH > 1) ? 1 : 0] : lvl[i];
            end
        end else if (i == DEPTH - 1) begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           lvl[i] <= '0;
                else if (do_shift_in) lvl[i] <= lvl[i-1];
            end
        end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            lvl[i] <= '0;
                else if (do_shift_in)  lvl[i] <= lvl[i-1];
                else if (do_shift_out) lvl[i] <= lvl[i+1];
            end
        end
    end

    assign top = lvl[0];

    // fill-state machine and count: next-state process
    always_comb begin
        fill_d  = fill_q;
        cnt_d   = cnt_q;
        ovf_evt = 1'b0;
        unf_evt = 1'b0;
        if (clear) begin
            fill_d = FILL_EMPTY;
            cnt_d  = '0;
        end else begin
            unique case (fill_q)
                FILL_EMPTY: begin
                    if (push) begin
                        cnt_d  = CNT_ONE;
                        fill_d = (CNT_ONE == CNT_MAX) ? FILL_FULL : FILL_PARTIAL;
                    end else if (pop) begin
                        unf_evt = 1'b1;
                    end
                end
                FILL_PARTIAL: begin
                    if (push) begin
                        cnt_d  = cnt_q + CNT_ONE;
                        fill_d = (cnt_q + CNT_ONE == CNT_MAX) ? FILL_FULL : FILL_PARTIAL;
                    end else if (pop) begin
                        cnt_d  = cnt_q - CNT_ONE;
                        fill_d = (cnt_q == CNT_ONE) ? FILL_EMPTY : FILL_PARTIAL;
                    end
                end
                FILL_FULL: begin
                    if (push) begin
                        ovf_evt = 1'b1;
                    end else if (pop) begin
                        cnt_d  = cnt_q - CNT_ONE;
                        fill_d = (cnt_q == CNT_ONE) ? FILL_EMPTY : FILL_PARTIAL;
                    end
                end
                default: begin
                    fill_d = FILL_EMPTY;
                    cnt_d  = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= FILL_EMPTY;
            cnt_q  <= '0;
        end else begin
            fill_q <= fill_d;
            cnt_q  <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        depth = cnt_q;
        full  = (fill_q == FILL_FULL);
        empty = (fill_q == FILL_EMPTY);
    end

    a_r10_empty_matches_count : assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == FILL_EMPTY) == (cnt_q == '0));

    a_r10_full_matches_count : assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == FILL_FULL) == (cnt_q == CNT_MAX));

    a_r8_push_full_stays_full : assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> (full && depth == CNT_MAX));

    a_r9_pop_empty_stays_empty : assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !clear) |=> (empty && $stable(top)));

    a_r4_push_grows : assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !clear) |=> (depth == $past(depth) + CNT_ONE && top == $past(push_val)));

endmodule

// File: rtl/prog_counter_stack.sv
module prog_counter_stack
    import pcs_pkg::*;
#(
    parameter int              PC_W    = 12,
    parameter int              OFF_W   = 8,
    parameter int              DEPTH   = 6,
    parameter logic [PC_W-1:0] RST_VEC = 12'hFFE,
    parameter logic [PC_W-1:0] IRQ_VEC = 12'hFF0,
    parameter int              CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             irq_i,
    input  logic [2:0]       op_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [CNT_W-1:0] depth_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             overflow_o,
    output logic             underflow_o
);

    logic [PC_W-1:0] pc_q, nxt_pc, top, push_val;
    logic            push, pop, ovf_evt, unf_evt;
    logic            ovf_q, unf_q;

    pcs_next_sel #(
        .PC_W    (PC_W),
        .OFF_W   (OFF_W),
        .RST_VEC (RST_VEC),
        .IRQ_VEC (IRQ_VEC)
    ) i_sel (
        .restart  (restart_i),
        .irq      (irq_i),
        .op       (op_i),
        .pc       (pc_q),
        .target   (target_i),
        .offset   (offset_i),
        .top      (top),
        .nxt_pc   (nxt_pc),
        .push     (push),
        .pop      (pop),
        .push_val (push_val)
    );

    pcs_ret_stack #(
        .PC_W  (PC_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart_i),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .top      (top),
        .depth    (depth_o),
        .full     (full_o),
        .empty    (empty_o),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= RST_VEC;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            pc_q <= nxt_pc;
            if (restart_i) begin
                ovf_q <= 1'b0;
                unf_q <= 1'b0;
            end else begin
                if (ovf_evt) ovf_q <= 1'b1;
                if (unf_evt) unf_q <= 1'b1;
            end
        end
    end

    assign pc_o        = pc_q;
    assign overflow_o  = ovf_q;
    assign underflow_o = unf_q;

    a_r1_restart_vector : assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pc_o == RST_VEC && depth_o == '0 && !overflow_o && !underflow_o));

    a_r2_step_increments : assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !irq_i && op_i == 3'd0) |=> (pc_o == PC_W'($past(pc_o) + PC_W'(1))));

    a_r3_jump_keeps_depth : assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !irq_i && op_i == 3'd1) |=> (pc_o == $past(target_i) && $stable(depth_o)));

    a_r6_irq_vector : assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && !restart_i) |=> (pc_o == IRQ_VEC));

    a_r8_overflow_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !restart_i) |=> overflow_o);

    a_r9_underflow_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && !restart_i) |=> underflow_o);

endmodule

// File: tb/test_prog_counter_stack.sv
`timescale 1ns/1ps
module test_prog_counter_stack;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        restart_i;
    logic        irq_i;
    logic [2:0]  op_i;
    logic [11:0] target_i;
    logic [7:0]  offset_i;
    logic [11:0] pc_o;
    logic [2:0]  depth_o;
    logic        full_o, empty_o, overflow_o, underflow_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    prog_counter_stack i_prog_counter_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (restart_i),
        .irq_i       (irq_i),
        .op_i        (op_i),
        .target_i    (target_i),
        .offset_i    (offset_i),
        .pc_o        (pc_o),
        .depth_o     (depth_o),
        .full_o      (full_o),
        .empty_o     (empty_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    // {req4, restart1, irq1, op3, target12, offset8, exp_pc12, exp_depth3, exp_ovf1, exp_unf1}
    localparam int NV = 34;
    localparam logic [45:0] VEC [NV] = '{
        {4'd2, 1'b0,1'b0,3'd0,12'h000,8'h00, 12'hFFF,3'd0,1'b0,1'b0}, // R2 step
        {4'd2, 1'b0,1'b0,3'd0,12'h000,8'h00, 12'h000,3'd0,1'b0,1'b0}, // R2 wrap to zero
        {4'd2, 1'b0,1'b0,3'd7,12'h555,8'h00, 12'h001,3'd0,1'b0,1'b0}, // R2 spare code
        {4'd3, 1'b0,1'b0,3'd1,12'h123,8'h00, 12'h123,3'd0,1'b0,1'b0}, // R3 jump
        {4'd5, 1'b0,1'b0,3'd3,12'h000,8'h10, 12'h133,3'd0,1'b0,1'b0}, // R5 forward
        {4'd5, 1'b0,1'b0,3'd3,12'h000,8'hF0, 12'h123,3'd0,1'b0,1'b0}, // R5 backward
        {4'd4, 1'b0,1'b0,3'd2,12'h400,8'h00, 12'h400,3'd1,1'b0,1'b0}, // R4 call
        {4'd6, 1'b0,1'b1,3'd1,12'h777,8'h00, 12'hFF0,3'd2,1'b0,1'b0}, // R6 irq beats jump
        {4'd2, 1'b0,1'b0,3'd0,12'h000,8'h00, 12'hFF1,3'd2,1'b0,1'b0}, // R2
        {4'd7, 1'b0,1'b0,3'd5,12'h000,8'h00, 12'h400,3'd1,1'b0,1'b0}, // R7 reti
        {4'd7, 1'b0,1'b0,3'd4,12'h000,8'h00, 12'h124,3'd0,1'b0,1'b0}, // R7 ret
        {4'd5, 1'b0,1'b0,3'd3,12'h000,8'h80, 12'h0A4,3'd0,1'b0,1'b0}, // R5 -128
        {4'd5, 1'b0,1'b0,3'd3,12'h000,8'h7F, 12'h123,3'd0,1'b0,1'b0}, // R5 +127
        {4'd4, 1'b0,1'b0,3'd2,12'h200,8'h00, 12'h200,3'd1,1'b0,1'b0}, // R4 nest 1
        {4'd4, 1'b0,1'b0,3'd2,12'h210,8'h00, 12'h210,3'd2,1'b0,1'b0}, // R4 nest 2
        {4'd4, 1'b0,1'b0,3'd2,12'h220,8'h00, 12'h220,3'd3,1'b0,1'b0}, // R4 nest 3
        {4'd4, 1'b0,1'b0,3'd2,12'h230,8'h00, 12'h230,3'd4,1'b0,1'b0}, // R4 nest 4
        {4'd4, 1'b0,1'b0,3'd2,12'h240,8'h00, 12'h240,3'd5,1'b0,1'b0}, // R4 nest 5
        {4'd10,1'b0,1'b0,3'd2,12'h250,8'h00, 12'h250,3'd6,1'b0,1'b0}, // R10 full
        {4'd8, 1'b0,1'b0,3'd2,12'h260,8'h00, 12'h260,3'd6,1'b1,1'b0}, // R8 overflow
        {4'd7, 1'b0,1'b0,3'd4,12'h000,8'h00, 12'h251,3'd5,1'b1,1'b0}, // R7 unwind
        {4'd7, 1'b0,1'b0,3'd4,12'h000,8'h00, 12'h241,3'd4,1'b1,1'b0},
        {4'd7, 1'b0,1'b0,3'd5,12'h000,8'h00, 12'h231,3'd3,1'b1,1'b0},
        {4'd7, 1'b0,1'b0,3'd4,12'h000,8'h00, 12'h221,3'd2,1'b1,1'b0},
        {4'd7, 1'b0,1'b0,3'd4,12'h000,8'h00, 12'h211,3'd1,1'b1,1'b0},
        {4'd10,1'b0,1'b0,3'd4,12'h000,8'h00, 12'h201,3'd0,1'b1,1'b0}, // R10 empty again
        {4'd9, 1'b0,1'b0,3'd4,12'h000,8'h00, 12'h201,3'd0,1'b1,1'b1}, // R9 underflow
        {4'd1, 1'b1,1'b1,3'd2,12'h333,8'h00, 12'hFFE,3'd0,1'b0,1'b0}, // R1 restart wins
        {4'd4, 1'b0,1'b0,3'd2,12'h050,8'h00, 12'h050,3'd1,1'b0,1'b0}, // R4
        {4'd6, 1'b0,1'b1,3'd4,12'h000,8'h00, 12'hFF0,3'd2,1'b0,1'b0}, // R6 irq beats ret
        {4'd7, 1'b0,1'b0,3'd4,12'h000,8'h00, 12'h050,3'd1,1'b0,1'b0}, // R7
        {4'd7, 1'b0,1'b0,3'd5,12'h000,8'h00, 12'hFFF,3'd0,1'b0,1'b0}, // R7
        {4'd5, 1'b0,1'b0,3'd3,12'h000,8'h05, 12'h004,3'd0,1'b0,1'b0}, // R5 wrap
        {4'd1, 1'b1,1'b0,3'd1,12'h999,8'h00, 12'hFFE,3'd0,1'b0,1'b0}  // R1 restart
    };

    task automatic check(input int req, input logic [11:0] e_pc, input logic [2:0] e_dep,
                         input logic e_ovf, input logic e_unf);
        logic e_full, e_empty;
        e_full  = (e_dep == 3'd6);
        e_empty = (e_dep == 3'd0);
        n_chk++;
        if (pc_o !== e_pc || depth_o !== e_dep || overflow_o !== e_ovf ||
            underflow_o !== e_unf || full_o !== e_full || empty_o !== e_empty) begin
            n_fail++;
            $display("FAIL R%0d: pc=%h depth=%0d ovf=%b unf=%b full=%b empty=%b expected pc=%h depth=%0d ovf=%b unf=%b full=%b empty=%b",
                     req, pc_o, depth_o, overflow_o, underflow_o, full_o, empty_o,
                     e_pc, e_dep, e_ovf, e_unf, e_full, e_empty);
        end
    endtask

    task automatic finish_up;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; restart_i = 1'b0; irq_i = 1'b0;
        op_i = 3'd0; target_i = '0; offset_i = '0;
        repeat (3) @(negedge clk);
        check(1, 12'hFFE, 3'd0, 1'b0, 1'b0); // R1 state during reset
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            restart_i = VEC[i][41];
            irq_i     = VEC[i][40];
            op_i      = VEC[i][39:37];
            target_i  = VEC[i][36:25];
            offset_i  = VEC[i][24:17];
            @(negedge clk);
            check(int'(VEC[i][45:42]), VEC[i][16:5], VEC[i][4:2], VEC[i][1], VEC[i][0]);
        end

        // R4 then R6, then asynchronous reset with entries held (R1)
        restart_i = 1'b0; irq_i = 1'b0; op_i = 3'd2; target_i = 12'h321;
        @(negedge clk);
        check(4, 12'h321, 3'd1, 1'b0, 1'b0);
        op_i = 3'd0; irq_i = 1'b1;
        @(negedge clk);
        check(6, 12'hFF0, 3'd2, 1'b0, 1'b0);
        irq_i = 1'b0;
        rst_n = 1'b0;
        #1;
        check(1, 12'hFFE, 3'd0, 1'b0, 1'b0); // R1 asynchronous
        @(negedge clk);
        rst_n = 1'b1;

        // R10 / R8: nested interrupt entries fill the stack, one more overflows
        for (int k = 1; k <= 7; k++) begin
            irq_i = 1'b1;
            @(negedge clk);
            if (k <= 6) check(10, 12'hFF0, 3'(k), 1'b0, 1'b0);
            else        check(8, 12'hFF0, 3'd6, 1'b1, 1'b0);
        end
        irq_i = 1'b0; op_i = 3'd4;
        @(negedge clk);
        check(7, 12'hFF0, 3'd5, 1'b1, 1'b0); // R7 pop of a vector-entry return
        op_i = 3'd0; restart_i = 1'b1;
        @(negedge clk);
        check(1, 12'hFFE, 3'd0, 1'b0, 1'b0); // R1 clears sticky flag
        restart_i = 1'b0;
        @(negedge clk);
        check(2, 12'hFFF, 3'd0, 1'b0, 1'b0); // R2 after restart

        finish_up();
    end

endmodule